// File: doc/BRIEF.md
# Single-Cycle Integer Core for a Twelve-Instruction Subset

This block is a processor core that runs each instruction in one clock period. In that one period it fetches a word from its instruction store, decodes it, reads up to two source registers, computes in the ALU, accesses its data store and writes one register back. The next program counter, either sequential or a branch target, is loaded on the rising edge. The instruction and data stores are arrays inside the core. They are filled while reset is held. There is no fetch or load/store handshake: every access completes in the cycle it is issued, so there is no back-pressure to manage.

A small decoder turns the opcode and function fields into the controls for three datapath multiplexers. These pick the destination register field, the second ALU operand (register or extended immediate) and the write-back source (ALU or memory). The decoder also drives the memory and register write enables, the ALU operation and the branch-taken select. The branch target is formed by its own adder, while the ALU compares the two registers by subtraction. The ports show the program counter, the register write-back and the data-memory access of the instruction now executing. A system connects through them for observation.

Top module: `sc_core`

## Requirements
- R1: While rst_n is low, pc_o is 0 and rf_we_o, dm_re_o and dm_we_o are all 0, whatever word sits at address 0. The register file is cleared to zero.
- R2: Every instruction other than a taken branch advances pc_o by 4 at the next rising edge. Instruction fetch uses pc_o bits above bit 1 as a word index.
- R3: R-type instructions (opcode 000000) write register rd (bits 15:11) with rs op rt. The function codes are add 100000, sub 100010, and 100100, or 100101 and slt 101010. slt gives 1 when rs is less than rt as signed values, else 0.
- R4: addi (opcode 001000) writes rt (bits 20:16) with rs plus the 16-bit immediate sign-extended. andi (001100) and ori (001101) use the immediate zero-extended.
- R5: lw (opcode 100011) drives dm_re_o with dm_addr_o = rs + sign-extended offset. It writes rt with the data word at address bits 31:2.
- R6: sw (opcode 101011) drives dm_we_o with dm_addr_o = rs + sign-extended offset and dm_wdata_o = rt. It writes no register, and a later lw from that address returns the stored word. dm_re_o and dm_we_o are never 1 together.
- R7: beq (opcode 000100) with rs equal to rt sets the next pc_o to pc+4 + (sign-extended immediate × 4). Otherwise the next pc_o is pc+4. beq writes no register.
- R8: bne (opcode 000101) branches to the same target when rs differs from rt, and otherwise falls through to pc+4. bne writes no register.
- R9: Register 0 always reads as zero. A write aimed at it leaves it zero.
- R10: An opcode outside the listed set behaves as a no-op. No write enable or read enable is raised, and pc_o advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_o | output | 32 | Address of the instruction now executing |
| rf_we_o | output | 1 | Register write-back enable of this instruction |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Value written back at the next edge |
| dm_re_o | output | 1 | Data memory read strobe |
| dm_we_o | output | 1 | Data memory write strobe |
| dm_addr_o | output | 32 | Byte address of the data access |
| dm_wdata_o | output | 32 | Store data |

## Verification
Some properties hold on every cycle, and the bound checker watches these. It checks reset quiescence, the sequential PC step, the branch-target arithmetic whenever a branch is taken, exclusive memory strobes and the absence of write-back on stores. It also checks that unknown opcodes raise no enable and that only branch opcodes redirect the PC. Other behaviour depends on register and memory state built up by earlier instructions, and only the directed programs in the bench can show it. This covers each ALU function's result, signed slt, sign- versus zero-extension, store-then-load through the data array, register 0 holding zero after a write, and the branch direction for equal and unequal operands.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_ANDI  = 6'b001100;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_BNE   = 6'b000101;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  localparam logic [XLEN-1:0] NOP_WORD = 32'hFC00_0000;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;
    logic    op2_imm;
    logic    wb_mem;
    logic    reg_wr;
    logic    mem_rd;
    logic    mem_wr;
    logic    branch;
    logic    br_ne;
    logic    imm_zx;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_wr = 1'b1;
        unique case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_wr = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl.op2_imm = 1'b1;
        ctrl.reg_wr  = 1'b1;
      end
      OP_ANDI: begin
        ctrl.op2_imm = 1'b1;
        ctrl.reg_wr  = 1'b1;
        ctrl.imm_zx  = 1'b1;
        ctrl.alu_op  = ALU_AND;
      end
      OP_ORI: begin
        ctrl.op2_imm = 1'b1;
        ctrl.reg_wr  = 1'b1;
        ctrl.imm_zx  = 1'b1;
        ctrl.alu_op  = ALU_OR;
      end
      OP_LW: begin
        ctrl.op2_imm = 1'b1;
        ctrl.reg_wr  = 1'b1;
        ctrl.wb_mem  = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OP_SW: begin
        ctrl.op2_imm = 1'b1;
        ctrl.mem_wr  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_BNE: begin
        ctrl.branch = 1'b1;
        ctrl.br_ne  = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    ra1,
  input  logic [AW-1:0]    ra2,
  output logic [WIDTH-1:0] rd1,
  output logic [WIDTH-1:0] rd2,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd
);
  logic [WIDTH-1:0] regs [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NREGS      = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [31:0]     pc_o,
  output logic            rf_we_o,
  output logic [4:0]      rf_waddr_o,
  output logic [31:0]     rf_wdata_o,
  output logic            dm_re_o,
  output logic            dm_we_o,
  output logic [31:0]     dm_addr_o,
  output logic [31:0]     dm_wdata_o
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) imem[i] = NOP_WORD;
  end

  logic [XLEN-1:0] pc_q, pc_plus4, br_target, pc_next;
  logic [XLEN-1:0] instr, imm_ext, rd1, rd2, alu_b, alu_y, dm_rdata, wb_data;
  logic [RIDX-1:0] waddr;
  logic            alu_zero, pc_src, rf_we, dm_we, dm_re;
  ctrl_t           ctl;

  assign instr = imem[pc_q[IAW+1:2]];

  sc_decoder u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctl)
  );

  assign waddr   = ctl.dst_rd ? instr[15:11] : instr[20:16];
  assign imm_ext = ctl.imm_zx ? {16'b0, instr[15:0]} : {{16{instr[15]}}, instr[15:0]};

  assign rf_we = rst_n & ctl.reg_wr;
  assign dm_we = rst_n & ctl.mem_wr;
  assign dm_re = rst_n & ctl.mem_rd;

  sc_regfile #(.NREGS(NREGS), .WIDTH(XLEN)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra1   (instr[25:21]),
    .ra2   (instr[20:16]),
    .rd1   (rd1),
    .rd2   (rd2),
    .we    (rf_we),
    .wa    (waddr),
    .wd    (wb_data)
  );

  assign alu_b = ctl.op2_imm ? imm_ext : rd2;

  sc_alu u_alu (
    .op   (ctl.alu_op),
    .a    (rd1),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign dm_rdata = dmem[alu_y[DAW+1:2]];
  assign wb_data  = ctl.wb_mem ? dm_rdata : alu_y;

  always_ff @(posedge clk) begin
    if (dm_we) dmem[alu_y[DAW+1:2]] <= rd2;
  end

  assign pc_src    = ctl.branch & (alu_zero ^ ctl.br_ne);
  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign pc_next   = pc_src ? br_target : pc_plus4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], pc_q[1:0], alu_y[1:0]};

  assign pc_o       = pc_q;
  assign rf_we_o    = rf_we;
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = wb_data;
  assign dm_re_o    = dm_re;
  assign dm_we_o    = dm_we;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rd2;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] instr,
  input logic        pc_src,
  input logic [31:0] pc_o,
  input logic        rf_we_o,
  input logic        dm_re_o,
  input logic        dm_we_o
);
  logic [5:0]  opc;
  logic        known_op, is_branch;
  logic [31:0] br_off;

  assign opc       = instr[31:26];
  assign is_branch = (opc == 6'b000100) || (opc == 6'b000101);
  assign known_op  = is_branch || (opc == 6'b000000) || (opc == 6'b001000) ||
                     (opc == 6'b001100) || (opc == 6'b001101) ||
                     (opc == 6'b100011) || (opc == 6'b101011);
  assign br_off    = {{14{instr[15]}}, instr[15:0], 2'b00};

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (pc_o == 32'd0 && !rf_we_o && !dm_re_o && !dm_we_o));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(pc_src)) |-> (pc_o == $past(pc_o) + 32'd4));

  // R7
  branch_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pc_src)) |-> (pc_o == $past(pc_o) + 32'd4 + $past(br_off)));

  // R8
  redirect_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_src |-> (is_branch && !rf_we_o));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dm_re_o && dm_we_o));

  // R6
  store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we_o |-> !rf_we_o);

  // R10
  unknown_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !known_op |-> (!rf_we_o && !dm_we_o && !dm_re_o && !pc_src));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .instr   (instr),
  .pc_src  (pc_src),
  .pc_o    (pc_o),
  .rf_we_o (rf_we_o),
  .dm_re_o (dm_re_o),
  .dm_we_o (dm_we_o)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]  rf_waddr_o;
  logic        rf_we_o, dm_re_o, dm_we_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sc_core uut (
    .clk(clk), .rst_n(rst_n), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_re_o(dm_re_o), .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      uut.imem[i] = 32'hFC00_0000;
      uut.dmem[i] = 32'd0;
    end
  endtask

  task automatic go();
    @(negedge clk); rst_n = 1'b1; #1;
  endtask

  task automatic hold_reset();
    @(negedge clk); rst_n = 1'b0; #1;
    clear_mem();
  endtask

  task automatic exp_wb(input string req, input logic [31:0] pc, input logic [4:0] wa,
                        input logic [31:0] wd);
    chk(req, "pc", pc_o, pc);
    chk(req, "rf_we", {31'd0, rf_we_o}, 32'd1);
    chk(req, "waddr", {27'd0, rf_waddr_o}, {27'd0, wa});
    chk(req, "wdata", rf_wdata_o, wd);
    step();
  endtask

  task automatic t_reset();
    hold_reset();
    uut.imem[0] = enc_i(6'b001000, 5'd0, 5'd1, 16'd5);
    for (int k = 0; k < 3; k++) begin
      chk("R1", "pc", pc_o, 32'd0);
      chk("R1", "enables", {29'd0, rf_we_o, dm_re_o, dm_we_o}, 32'd0);
      step();
    end
  endtask

  task automatic t_alu();
    hold_reset();
    uut.imem[0]  = enc_i(6'b001000, 5'd0, 5'd1, 16'd7);
    uut.imem[1]  = enc_i(6'b001000, 5'd0, 5'd2, 16'hFFFD);
    uut.imem[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'b100000);
    uut.imem[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'b100010);
    uut.imem[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'b100100);
    uut.imem[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'b100101);
    uut.imem[6]  = enc_r(5'd2, 5'd1, 5'd7, 6'b101010);
    uut.imem[7]  = enc_r(5'd1, 5'd2, 5'd8, 6'b101010);
    uut.imem[8]  = enc_i(6'b001100, 5'd2, 5'd9, 16'hFFF0);
    uut.imem[9]  = enc_i(6'b001101, 5'd0, 5'd10, 16'h8001);
    go();
    exp_wb("R4", 32'd0,  5'd1,  32'd7);
    exp_wb("R4", 32'd4,  5'd2,  32'hFFFF_FFFD);
    exp_wb("R3", 32'd8,  5'd3,  32'd4);
    exp_wb("R3", 32'd12, 5'd4,  32'd10);
    exp_wb("R3", 32'd16, 5'd5,  32'd5);
    exp_wb("R3", 32'd20, 5'd6,  32'hFFFF_FFFF);
    exp_wb("R3", 32'd24, 5'd7,  32'd1);
    exp_wb("R3", 32'd28, 5'd8,  32'd0);
    exp_wb("R4", 32'd32, 5'd9,  32'h0000_FFF0);
    exp_wb("R4", 32'd36, 5'd10, 32'h0000_8001);
    chk("R2", "pc", pc_o, 32'd40);
  endtask

  task automatic t_mem();
    hold_reset();
    uut.dmem[5] = 32'hCAFE_F00D;
    uut.imem[0] = enc_i(6'b001000, 5'd0, 5'd1, 16'd24);
    uut.imem[1] = enc_i(6'b100011, 5'd1, 5'd2, 16'hFFFC);
    uut.imem[2] = enc_i(6'b101011, 5'd1, 5'd2, 16'd8);
    uut.imem[3] = enc_i(6'b100011, 5'd1, 5'd3, 16'd8);
    go();
    exp_wb("R4", 32'd0, 5'd1, 32'd24);
    chk("R5", "dm_re", {31'd0, dm_re_o}, 32'd1);
    chk("R5", "dm_addr", dm_addr_o, 32'd20);
    exp_wb("R5", 32'd4, 5'd2, 32'hCAFE_F00D);
    chk("R6", "dm_we", {31'd0, dm_we_o}, 32'd1);
    chk("R6", "dm_re", {31'd0, dm_re_o}, 32'd0);
    chk("R6", "rf_we", {31'd0, rf_we_o}, 32'd0);
    chk("R6", "dm_addr", dm_addr_o, 32'd32);
    chk("R6", "dm_wdata", dm_wdata_o, 32'hCAFE_F00D);
    step();
    exp_wb("R6", 32'd12, 5'd3, 32'hCAFE_F00D);
  endtask

  task automatic t_branch();
    hold_reset();
    uut.imem[0] = enc_i(6'b001000, 5'd0, 5'd1, 16'd5);
    uut.imem[1] = enc_i(6'b001000, 5'd0, 5'd2, 16'd5);
    uut.imem[2] = enc_i(6'b000100, 5'd1, 5'd2, 16'd2);
    uut.imem[5] = enc_i(6'b000101, 5'd1, 5'd2, 16'd5);
    uut.imem[6] = enc_i(6'b000100, 5'd1, 5'd0, 16'd1);
    uut.imem[7] = enc_i(6'b000101, 5'd1, 5'd0, 16'hFFF8);
    go();
    step(); step();
    chk("R7", "pc", pc_o, 32'd8);
    chk("R7", "rf_we", {31'd0, rf_we_o}, 32'd0);
    step();
    chk("R7", "taken target", pc_o, 32'd20);
    chk("R8", "rf_we", {31'd0, rf_we_o}, 32'd0);
    step();
    chk("R8", "not taken", pc_o, 32'd24);
    step();
    chk("R7", "not taken", pc_o, 32'd28);
    step();
    chk("R8", "backward target", pc_o, 32'd0);
  endtask

  task automatic t_zero_reg();
    hold_reset();
    uut.imem[0] = enc_i(6'b001000, 5'd0, 5'd0, 16'd9);
    uut.imem[1] = enc_r(5'd0, 5'd0, 5'd1, 6'b100000);
    uut.imem[2] = enc_i(6'b001101, 5'd0, 5'd2, 16'd3);
    go();
    step();
    exp_wb("R9", 32'd4, 5'd1, 32'd0);
    exp_wb("R9", 32'd8, 5'd2, 32'd3);
  endtask

  task automatic t_unknown();
    hold_reset();
    uut.imem[0] = enc_i(6'b111111, 5'd1, 5'd1, 16'd1);
    uut.imem[1] = enc_r(5'd3, 5'd4, 5'd5, 6'b000111);
    uut.imem[2] = enc_i(6'b001000, 5'd0, 5'd1, 16'd1);
    go();
    chk("R10", "enables", {29'd0, rf_we_o, dm_re_o, dm_we_o}, 32'd0);
    step();
    chk("R10", "pc", pc_o, 32'd4);
    step();
    exp_wb("R10", 32'd8, 5'd1, 32'd1);
  endtask

  initial begin
    t_reset();
    t_alu();
    t_mem();
    t_branch();
    t_zero_reg();
    t_unknown();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule